// File: doc/BRIEF.md
# Serial RAM Transaction Sequencer

This block turns single-word read and write requests into complete serial-bus transactions for an external RAM. Each transaction selects the device, sends an 8-bit opcode, then an address of programmable length. An optional run of idle (dummy) clocks follows, and the transaction ends with exactly 32 bits of data. The serial clock runs at half the system clock. Every phase of a transaction uses the same lane width: one, two, four or eight data lanes.

Requests arrive on a valid/ready channel. `req_ready` is high only while the sequencer is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. All static configuration inputs are sampled at that same edge and held for the whole transaction. A read returns its word on a valid/ready response channel. The response stays valid, with its data held, until the consumer raises `rsp_ready`. No new request is accepted before then, so back-pressure on responses stalls the request side. Writes produce no response.

Top module: `spiram_seq`

## Requirements
- R1: `req_ready` is high exactly when no transaction is in progress and no response is pending. A request is accepted on an edge with `req_valid && req_ready`. Request fields and all `cfg_*` inputs are captured at that edge.
- R2: `spi_cs_n` falls on the edge that accepts the request. Each serial clock cycle is two system clocks, low then high. `spi_sclk` is low whenever `spi_cs_n` is high. `spi_cs_n` rises one system clock after the last falling serial edge. A transaction of N serial cycles therefore holds `spi_cs_n` low for 2N+1 system clocks.
- R3: The opcode is 8 bits, most significant bit first. Reads send 0x03 when `cfg_rd_op_sel` is 0 and `cfg_rd_opcode` when it is 1. Writes send 0x02 when `cfg_wr_op_sel` is 0 and `cfg_wr_opcode` when it is 1.
- R4: The address phase carries `cfg_addr_len_m1`+1 bits: the low bits of `req_addr`, zero-extended, most significant first. If the length is not a multiple of the lane width, the last cycle is padded with zeros on its low lanes.
- R5: When `cfg_addr32` is 1, the address phase is exactly 32 bits and `cfg_addr_len_m1` is ignored.
- R6: The dummy phase lasts `cfg_rd_dummy_m1`+1 serial cycles for a read and `cfg_wr_dummy_m1`+1 for a write. It is present only when that direction's enable (`cfg_rd_dummy_en` / `cfg_wr_dummy_en`) is 1, and the other direction's settings have no effect. All output enables are low during the dummy phase.
- R7: Lane width priority is octal, then quad, then dual. With none of the three set, the bus is single-lane: output on lane 0, input on lane 1. With W lanes, each serial cycle carries the next W stream bits, and lane W-1 holds the most significant of them.
- R8: During command, address and write-data phases, `spi_oe` is high on exactly the active output lanes (bit 0 only in single-lane mode). Write data is the 32 bits of `req_wdata`, most significant first.
- R9: During read data all output enables are low. Input lanes are sampled on the system edge that ends each high half of the serial clock, and 32 bits are assembled in arrival order, the first bit arriving becoming the most significant. `rsp_valid` rises with `spi_cs_n` and stays high, with `rsp_data` stable, until `rsp_ready`.
- R10: After reset and between transactions, `spi_cs_n` is 1, `spi_sclk` is 0, `spi_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer idle, can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_data | output | 32 | Assembled read word |
| cfg_addr32 | input | 1 | Force a 32-bit address phase |
| cfg_addr_len_m1 | input | 6 | Address bits minus one |
| cfg_rd_dummy_en | input | 1 | Dummy phase on reads |
| cfg_rd_dummy_m1 | input | 6 | Read dummy cycles minus one |
| cfg_wr_dummy_en | input | 1 | Dummy phase on writes |
| cfg_wr_dummy_m1 | input | 6 | Write dummy cycles minus one |
| cfg_rd_op_sel | input | 1 | Use programmable read opcode |
| cfg_rd_opcode | input | 8 | Programmable read opcode |
| cfg_wr_op_sel | input | 1 | Use programmable write opcode |
| cfg_wr_opcode | input | 8 | Programmable write opcode |
| cfg_dual | input | 1 | Two-lane mode |
| cfg_quad | input | 1 | Four-lane mode |
| cfg_octal | input | 1 | Eight-lane mode |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_dout | output | 8 | Lane output data |
| spi_oe | output | 8 | Lane output enables |
| spi_din | input | 8 | Lane input data |

## Verification
The bench targets an address length that does not fill the last dual-lane cycle. A design that pads on the wrong side, or drops the short cycle, shifts every later bit and the transaction length. Several lane modes are set together to expose a wrong priority, which shows up as the wrong lane count and a changed chip-select width. The bench enables the dummy phase only for the opposite direction, so a design that mixes up the two directions inserts idle cycles. It also sets the 32-bit flag together with a small length field; a design that obeys the field sends a short address. Response back-pressure is held for several cycles, which catches a response that drops early, data that changes, or a new request accepted while a response is still pending.

// File: rtl/spiram_pkg.sv
package spiram_pkg;
  // Transaction phase; order is the order a transaction walks through.
  typedef enum logic [2:0] {
    PH_IDLE, PH_CMD, PH_ADDR, PH_DUMMY, PH_DATA, PH_HOLD, PH_RESP
  } phase_e;

  // log2 of the active lane count: 0 -> 1 lane ... 3 -> 8 lanes
  typedef logic [1:0] lane_lg_t;
endpackage

// File: rtl/spiram_lane_pick.sv
module spiram_lane_pick
  import spiram_pkg::*;
(
  input  logic     dual,
  input  logic     quad,
  input  logic     octal,
  output lane_lg_t lg
);
  // widest requested mode wins
  always_comb begin
    if (octal)     lg = 2'd3;
    else if (quad) lg = 2'd2;
    else if (dual) lg = 2'd1;
    else           lg = 2'd0;
  end
endmodule

// File: rtl/spiram_phase_len.sv
module spiram_phase_len
  import spiram_pkg::*;
#(
  parameter int CMD_W  = 8,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 6,
  parameter int CNT_W  = 9
) (
  input  lane_lg_t           lg,
  input  logic [LEN_W:0]     addr_bits,
  input  logic [LEN_W-1:0]   dum_m1,
  output logic [CNT_W-1:0]   cmd_cyc,
  output logic [CNT_W-1:0]   addr_cyc,
  output logic [CNT_W-1:0]   dum_cyc,
  output logic [CNT_W-1:0]   data_cyc
);
  logic [CNT_W-1:0] round_up;

  // serial cycles per phase at the chosen lane width
  always_comb begin
    round_up = (CNT_W'(1) << lg) - CNT_W'(1);
    cmd_cyc  = CNT_W'(CMD_W) >> lg;
    data_cyc = CNT_W'(DATA_W) >> lg;
    addr_cyc = (CNT_W'(addr_bits) + round_up) >> lg;
    dum_cyc  = CNT_W'(dum_m1) + CNT_W'(1);
  end
endmodule

// File: rtl/spiram_lane_io.sv
module spiram_lane_io
  import spiram_pkg::*;
#(
  parameter int LANES = 8
) (
  input  lane_lg_t           lg,
  input  logic               drive,
  input  logic [LANES-1:0]   sh_top,
  input  logic [LANES-1:0]   din,
  output logic [LANES-1:0]   dout,
  output logic [LANES-1:0]   oe,
  output logic [LANES-1:0]   din_bits
);
  int unsigned nl;

  always_comb begin
    nl = 32'd1 << lg;
    dout = '0;
    oe   = '0;
    for (int i = 0; i < LANES; i++) begin
      if (i < int'(nl)) begin
        dout[i] = drive & sh_top[LANES - int'(nl) + i];
        oe[i]   = drive;
      end
    end
    // single-lane input arrives on lane 1; wide modes use the low lanes
    din_bits = '0;
    if (lg == 2'd0) din_bits[0] = din[1];
    else begin
      for (int i = 0; i < LANES; i++)
        if (i < int'(nl)) din_bits[i] = din[i];
    end
  end
endmodule

// File: rtl/spiram_seq.sv
module spiram_seq
  import spiram_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CMD_W  = 8,
  parameter int LEN_W  = 6,
  parameter int LANES  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [DATA_W-1:0]  rsp_data,
  input  logic               cfg_addr32,
  input  logic [LEN_W-1:0]   cfg_addr_len_m1,
  input  logic               cfg_rd_dummy_en,
  input  logic [LEN_W-1:0]   cfg_rd_dummy_m1,
  input  logic               cfg_wr_dummy_en,
  input  logic [LEN_W-1:0]   cfg_wr_dummy_m1,
  input  logic               cfg_rd_op_sel,
  input  logic [CMD_W-1:0]   cfg_rd_opcode,
  input  logic               cfg_wr_op_sel,
  input  logic [CMD_W-1:0]   cfg_wr_opcode,
  input  logic               cfg_dual,
  input  logic               cfg_quad,
  input  logic               cfg_octal,
  output logic               spi_cs_n,
  output logic               spi_sclk,
  output logic [LANES-1:0]   spi_dout,
  output logic [LANES-1:0]   spi_oe,
  input  logic [LANES-1:0]   spi_din
);
  localparam int SH_W  = 1 << LEN_W;
  localparam int CNT_W = LEN_W + 3;

  localparam logic [CMD_W-1:0] OP_RD_DEF = CMD_W'(8'h03);
  localparam logic [CMD_W-1:0] OP_WR_DEF = CMD_W'(8'h02);

  phase_e               ph;
  logic                 hph;
  logic [CNT_W-1:0]     left;
  logic [SH_W-1:0]      sh;
  logic [DATA_W-1:0]    rdata;

  lane_lg_t             c_lg;
  logic                 c_wr;
  logic [LEN_W:0]       c_abits;
  logic                 c_den;
  logic [LEN_W-1:0]     c_dm1;
  logic [ADDR_W-1:0]    c_addr;
  logic [DATA_W-1:0]    c_wdata;

  lane_lg_t             lg_in, lg_eff;
  logic [LEN_W:0]       abits_in;
  logic [CMD_W-1:0]     op_in;
  logic [CNT_W-1:0]     cmd_cyc, addr_cyc, dum_cyc, data_cyc;
  logic [3:0]           step;
  logic                 drive;
  logic [LANES-1:0]     din_bits;
  logic [SH_W-1:0]      addr_load, data_load;
  logic [LEN_W:0]       addr_pad;

  spiram_lane_pick u_pick (
    .dual(cfg_dual), .quad(cfg_quad), .octal(cfg_octal), .lg(lg_in)
  );

  assign lg_eff = (ph == PH_IDLE) ? lg_in : c_lg;

  spiram_phase_len #(
    .CMD_W(CMD_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .CNT_W(CNT_W)
  ) u_len (
    .lg(lg_eff), .addr_bits(c_abits), .dum_m1(c_dm1),
    .cmd_cyc(cmd_cyc), .addr_cyc(addr_cyc), .dum_cyc(dum_cyc), .data_cyc(data_cyc)
  );

  assign drive = (ph == PH_CMD) || (ph == PH_ADDR) || (ph == PH_DATA && c_wr);

  spiram_lane_io #(.LANES(LANES)) u_io (
    .lg(c_lg), .drive(drive), .sh_top(sh[SH_W-1 -: LANES]), .din(spi_din),
    .dout(spi_dout), .oe(spi_oe), .din_bits(din_bits)
  );

  always_comb begin
    abits_in = cfg_addr32 ? (LEN_W+1)'(ADDR_W)
                          : (LEN_W+1)'(cfg_addr_len_m1) + (LEN_W+1)'(1);
    if (req_write) op_in = cfg_wr_op_sel ? cfg_wr_opcode : OP_WR_DEF;
    else           op_in = cfg_rd_op_sel ? cfg_rd_opcode : OP_RD_DEF;
    step      = 4'(1) << c_lg;
    addr_pad  = (LEN_W+1)'(SH_W) - c_abits;
    addr_load = SH_W'(c_addr) << addr_pad;
    data_load = {c_wdata, {(SH_W-DATA_W){1'b0}}};
  end

  assign req_ready = (ph == PH_IDLE);
  assign rsp_valid = (ph == PH_RESP);
  assign rsp_data  = rdata;
  assign spi_cs_n  = (ph == PH_IDLE) || (ph == PH_RESP);
  assign spi_sclk  = hph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE;  hph <= 1'b0;  left <= '0;  sh <= '0;  rdata <= '0;
      c_lg <= '0;  c_wr <= 1'b0;  c_abits <= '0;  c_den <= 1'b0;  c_dm1 <= '0;
      c_addr <= '0;  c_wdata <= '0;
    end else begin
      case (ph)
        PH_IDLE: if (req_valid) begin
          c_lg    <= lg_in;
          c_wr    <= req_write;
          c_abits <= abits_in;
          c_den   <= req_write ? cfg_wr_dummy_en : cfg_rd_dummy_en;
          c_dm1   <= req_write ? cfg_wr_dummy_m1 : cfg_rd_dummy_m1;
          c_addr  <= req_addr;
          c_wdata <= req_wdata;
          sh      <= {op_in, {(SH_W-CMD_W){1'b0}}};
          left    <= cmd_cyc;
          hph     <= 1'b0;
          ph      <= PH_CMD;
        end
        PH_CMD, PH_ADDR, PH_DUMMY, PH_DATA: begin
          hph <= ~hph;
          if (hph) begin
            sh   <= sh << step;
            left <= left - CNT_W'(1);
            if (ph == PH_DATA && !c_wr)
              rdata <= (rdata << step) | DATA_W'(din_bits);
            if (left == CNT_W'(1)) begin
              case (ph)
                PH_CMD: begin
                  ph <= PH_ADDR;  left <= addr_cyc;  sh <= addr_load;
                end
                PH_ADDR: if (c_den) begin
                  ph <= PH_DUMMY; left <= dum_cyc;
                end else begin
                  ph <= PH_DATA;  left <= data_cyc;  sh <= data_load;
                end
                PH_DUMMY: begin
                  ph <= PH_DATA;  left <= data_cyc;  sh <= data_load;
                end
                default: ph <= PH_HOLD;
              endcase
            end
          end
        end
        PH_HOLD: ph <= c_wr ? PH_IDLE : PH_RESP;
        PH_RESP: if (rsp_ready) ph <= PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // R1: acceptance selects the device on the next cycle
  a_r1_accept_selects: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !spi_cs_n);
  // R1: no request taken while a transaction is on the bus
  a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> !req_ready);
  // R2: serial clock idles low while deselected
  a_r2_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);
  // R2: a high half never lasts more than one system clock
  a_r2_sclk_half_rate: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |=> !spi_sclk);
  // R2: chip select released one clock after the hold cycle begins
  a_r2_cs_release: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_HOLD) |=> spi_cs_n);
  // R6: lanes released in the dummy phase
  a_r6_dummy_released: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_DUMMY) |-> (spi_oe == '0));
  // R9: lanes released while read data arrives
  a_r9_read_released: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_DATA && !c_wr) |-> (spi_oe == '0));
  // R9: response held under back-pressure
  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

// File: tb/sim_spiram_seq.sv
`timescale 1ns/1ps
module sim_spiram_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_data;
  logic        cfg_addr32 = 1'b0;
  logic [5:0]  cfg_addr_len_m1 = 6'd23;
  logic        cfg_rd_dummy_en = 1'b0, cfg_wr_dummy_en = 1'b0;
  logic [5:0]  cfg_rd_dummy_m1 = '0, cfg_wr_dummy_m1 = '0;
  logic        cfg_rd_op_sel = 1'b0, cfg_wr_op_sel = 1'b0;
  logic [7:0]  cfg_rd_opcode = '0, cfg_wr_opcode = '0;
  logic        cfg_dual = 1'b0, cfg_quad = 1'b0, cfg_octal = 1'b0;
  logic        spi_cs_n, spi_sclk;
  logic [7:0]  spi_dout, spi_oe;
  logic [7:0]  spi_din = '0;

  int checks = 0, errors = 0;
  int kcnt = 0;
  logic [7:0] seed = 8'h00;
  logic [7:0] cap_o [256];
  logic [7:0] cap_e [256];

  spiram_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .cfg_addr32(cfg_addr32), .cfg_addr_len_m1(cfg_addr_len_m1),
    .cfg_rd_dummy_en(cfg_rd_dummy_en), .cfg_rd_dummy_m1(cfg_rd_dummy_m1),
    .cfg_wr_dummy_en(cfg_wr_dummy_en), .cfg_wr_dummy_m1(cfg_wr_dummy_m1),
    .cfg_rd_op_sel(cfg_rd_op_sel), .cfg_rd_opcode(cfg_rd_opcode),
    .cfg_wr_op_sel(cfg_wr_op_sel), .cfg_wr_opcode(cfg_wr_opcode),
    .cfg_dual(cfg_dual), .cfg_quad(cfg_quad), .cfg_octal(cfg_octal),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_dout(spi_dout),
    .spi_oe(spi_oe), .spi_din(spi_din)
  );

  function automatic logic [7:0] pat(int k);
    return 8'((k * 29 + int'(seed)) ^ 8'h5a);
  endfunction

  // device model: record lanes at each rising serial edge, then present read data
  always @(posedge spi_sclk) begin
    #1;
    if (kcnt < 256) begin
      cap_o[kcnt] = spi_dout;
      cap_e[kcnt] = spi_oe;
    end
    spi_din = pat(kcnt);
    kcnt++;
  end

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one transaction, expectations derived from the requirement text
  task automatic run_txn(string req, bit wr, logic [31:0] addr, logic [31:0] wdata,
                         int hold);
    int w, L, ncmd, nadr, ndum, ndat, n, cs_low, guard, bad;
    logic [7:0] op, lmask, eo, ee;
    logic [63:0] a64;
    logic [31:0] exp_rd, got;
    w = cfg_octal ? 8 : cfg_quad ? 4 : cfg_dual ? 2 : 1;
    L = cfg_addr32 ? 32 : int'(cfg_addr_len_m1) + 1;
    op = wr ? (cfg_wr_op_sel ? cfg_wr_opcode : 8'h02)
            : (cfg_rd_op_sel ? cfg_rd_opcode : 8'h03);
    ncmd = 8 / w;
    nadr = (L + w - 1) / w;
    ndum = wr ? (cfg_wr_dummy_en ? int'(cfg_wr_dummy_m1) + 1 : 0)
              : (cfg_rd_dummy_en ? int'(cfg_rd_dummy_m1) + 1 : 0);
    ndat = 32 / w;
    n = ncmd + nadr + ndum + ndat;
    lmask = (w == 8) ? 8'hff : 8'((1 << w) - 1);
    a64 = {32'h0, addr};

    kcnt = 0;
    @(negedge clk);
    req_write = wr; req_addr = addr; req_wdata = wdata; req_valid = 1'b1;
    @(posedge clk);
    #1 req_valid = 1'b0;
    cs_low = 0; guard = 0;
    @(negedge clk);
    while (!spi_cs_n && guard < 1000) begin
      cs_low++; guard++;
      if (!spi_cs_n && req_ready) begin
        checks++; errors++;
        $display("FAIL R1 ready while busy: actual 1 expected 0");
      end
      @(negedge clk);
    end
    check("R2", "cs low clocks", 64'(cs_low), 64'(2 * n + 1));
    check("R2", "serial cycles", 64'(kcnt), 64'(n));

    // lane stream comparison
    bad = 0; exp_rd = '0;
    for (int k = 0; k < n && k < 256; k++) begin
      int g;
      bit drv;
      eo = '0; drv = 1'b0;
      if (k < ncmd) begin
        g = k; drv = 1'b1;
        for (int i = 0; i < w; i++) eo[i] = op[7 - (g * w + (w - 1 - i))];
      end else if (k < ncmd + nadr) begin
        g = k - ncmd; drv = 1'b1;
        for (int i = 0; i < w; i++) begin
          int p;
          p = g * w + (w - 1 - i);
          eo[i] = (p < L) ? a64[L - 1 - p] : 1'b0;
        end
      end else if (k >= ncmd + nadr + ndum) begin
        g = k - (ncmd + nadr + ndum);
        if (wr) begin
          drv = 1'b1;
          for (int i = 0; i < w; i++) eo[i] = wdata[31 - (g * w + (w - 1 - i))];
        end else begin
          for (int i = w - 1; i >= 0; i--) begin
            logic [7:0] pv;
            pv = pat(k);
            exp_rd = {exp_rd[30:0], pv[(w == 1) ? 1 : i]};
          end
        end
      end
      ee = drv ? lmask : 8'h00;
      if (cap_e[k] !== ee || (drv && ((cap_o[k] & lmask) !== eo))) begin
        if (bad == 0)
          $display("FAIL %s lane cycle %0d: actual out %0h oe %0h expected out %0h oe %0h",
                   req, k, cap_o[k] & lmask, cap_e[k], eo, ee);
        bad++;
      end
    end
    checks++;
    if (bad != 0) errors++;

    if (wr) begin
      check("R9", "no write response", 64'(rsp_valid), 64'(0));
      check("R1", "ready after write", 64'(req_ready), 64'(1));
    end else begin
      check("R9", "rsp_valid at cs rise", 64'(rsp_valid), 64'(1));
      check("R9", "read word", 64'(rsp_data), 64'(exp_rd));
      if (hold > 0) begin
        got = rsp_data;
        for (int h = 0; h < hold; h++) begin
          @(negedge clk);
          check("R9", "held valid", 64'(rsp_valid), 64'(1));
          check("R9", "held data", 64'(rsp_data), 64'(got));
          check("R1", "not ready while pending", 64'(req_ready), 64'(0));
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        check("R9", "valid drops after take", 64'(rsp_valid), 64'(0));
        check("R1", "ready after take", 64'(req_ready), 64'(1));
      end else begin
        @(negedge clk);
      end
    end
    check("R10", "idle oe", 64'(spi_oe), 64'(0));
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R10", "cs_n", 64'(spi_cs_n), 64'(1));
    check("R10", "sclk", 64'(spi_sclk), 64'(0));
    check("R10", "oe", 64'(spi_oe), 64'(0));
    check("R10", "req_ready", 64'(req_ready), 64'(1));
    check("R10", "rsp_valid", 64'(rsp_valid), 64'(0));
  endtask

  task automatic t_single_read_default;   // R3 R4 R7 R9
    seed = 8'h11;
    cfg_addr_len_m1 = 6'd23;
    run_txn("R3/R7/R9 single read", 1'b0, 32'h00A5_3C96, '0, 0);
  endtask

  task automatic t_write_prog_opcode;     // R3 R6 R8
    cfg_wr_op_sel = 1'b1; cfg_wr_opcode = 8'hA5;
    cfg_wr_dummy_en = 1'b1; cfg_wr_dummy_m1 = 6'd2;
    run_txn("R3/R6/R8 write", 1'b1, 32'h0012_3456, 32'hDEAD_BEEF, 0);
    cfg_wr_op_sel = 1'b0; cfg_wr_dummy_en = 1'b0;
  endtask

  task automatic t_quad_read_dummy;       // R6 R7 R9
    seed = 8'h3c;
    cfg_quad = 1'b1; cfg_rd_dummy_en = 1'b1; cfg_rd_dummy_m1 = 6'd5;
    cfg_rd_op_sel = 1'b1; cfg_rd_opcode = 8'hEB;
    run_txn("R6/R7 quad read", 1'b0, 32'h0077_1234, '0, 0);
    cfg_quad = 1'b0; cfg_rd_dummy_en = 1'b0; cfg_rd_op_sel = 1'b0;
  endtask

  task automatic t_octal_priority_addr32; // R5 R7
    cfg_octal = 1'b1; cfg_quad = 1'b1; cfg_dual = 1'b1;
    cfg_addr32 = 1'b1; cfg_addr_len_m1 = 6'd5;
    run_txn("R5/R7 octal write", 1'b1, 32'hC001_D00D, 32'h0123_4567, 0);
    cfg_octal = 1'b0; cfg_quad = 1'b0; cfg_dual = 1'b0;
    cfg_addr32 = 1'b0; cfg_addr_len_m1 = 6'd23;
  endtask

  task automatic t_dual_odd_addr;         // R4
    seed = 8'h77;
    cfg_dual = 1'b1; cfg_addr_len_m1 = 6'd6;
    run_txn("R4 dual 7-bit addr", 1'b0, 32'h0000_007F, '0, 0);
    cfg_dual = 1'b0; cfg_addr_len_m1 = 6'd23;
  endtask

  task automatic t_other_dir_dummy;       // R6
    cfg_rd_dummy_en = 1'b1; cfg_rd_dummy_m1 = 6'd9;
    cfg_wr_dummy_en = 1'b0; cfg_wr_dummy_m1 = 6'd4;
    run_txn("R6 write ignores read dummy", 1'b1, 32'h0000_1000, 32'hA5A5_0F0F, 0);
    cfg_rd_dummy_en = 1'b0;
  endtask

  task automatic t_quad_over_dual;        // R7
    cfg_quad = 1'b1; cfg_dual = 1'b1;
    run_txn("R7 quad beats dual", 1'b1, 32'h00FE_DCBA, 32'h8000_0001, 0);
    cfg_quad = 1'b0; cfg_dual = 1'b0;
  endtask

  task automatic t_backpressure;          // R1 R9
    seed = 8'hc3;
    rsp_ready = 1'b0;
    run_txn("R1/R9 back-pressure", 1'b0, 32'h0055_AA55, '0, 5);
    rsp_ready = 1'b1;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_single_read_default();
    t_write_prog_opcode();
    t_quad_read_dummy();
    t_octal_priority_addr32();
    t_dual_odd_addr();
    t_other_dir_dummy();
    t_quad_over_dual();
    t_backpressure();
    t_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule